// File: doc/BRIEF.md
# UART Receive Character Deframer

This block turns an asynchronous serial input into whole characters. A free-running enable pulses at sixteen times the bit rate. Each pulse advances an oversampling counter. The line passes through a two-flop synchronizer. After that, a falling edge starts a candidate frame. The candidate is confirmed only if the line is still low half a bit later. Every following bit is taken at its centre.

The same line-control inputs that set up the transmitter also set up this receiver. These inputs select a 7- or 8-bit word, turn the parity bit on or off, choose odd or even parity, and choose a fixed (stick) parity value. When a frame's first stop bit is sampled, the block pulses a valid strobe for one clock. In that same clock it presents the byte, together with flags for a parity error, a framing error and a line break. Queueing of characters, timeouts and software access belong to the surrounding logic.

Top module: `uart_rx_deframer`

## Requirements
- R1: When `wlen8_i` is 1, a character has 8 data bits. When it is 0, a character has 7 data bits and `data_o[7]` reads 0.
- R2: Data bits arrive least-significant first. Each bit is sampled at its centre, so the byte on `data_o` matches the transmitted bits.
- R3: When `par_en_i` is 0, no parity bit is expected on the line, and `par_err_o` is never raised.
- R4: When `par_en_i` is 1 and `stick_i` is 0, the receiver counts the ones across the data bits plus the parity bit. With `even_sel_i` 1 the count must be even, and with `even_sel_i` 0 it must be odd. Otherwise `par_err_o` pulses with the character.
- R5: When `par_en_i` is 1 and `stick_i` is 1, the parity bit must equal the inverse of `even_sel_i`, whatever the data bits are. Otherwise `par_err_o` pulses.
- R6: `frm_err_o` pulses when the first stop bit samples 0. Nothing after the first stop bit is examined.
- R7: The start bit of the next character may follow the first stop bit directly. Both characters are then received correctly.
- R8: `brk_o` pulses, together with `frm_err_o`, when every data bit, the parity bit (if enabled) and the first stop bit all sample 0. No further character is reported until the line has gone high again.
- R9: A low pulse shorter than half a bit period is ignored. No strobe follows it.
- R10: `valid_o` is high for exactly one clock per character, during the first stop bit. The three flags are only ever high in that same clock.
- R11: After reset, `valid_o`, `par_err_o`, `frm_err_o` and `brk_o` are 0, and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | One-clock enable at 16x the bit rate |
| wlen8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | 1: a parity bit follows the data |
| even_sel_i | input | 1 | 1: even parity, 0: odd parity |
| stick_i | input | 1 | 1: parity bit is fixed at the inverse of even_sel_i |
| data_o | output | 8 | Last received character |
| valid_o | output | 1 | One-clock strobe per character |
| par_err_o | output | 1 | Parity mismatch for this character |
| frm_err_o | output | 1 | First stop bit sampled low |
| brk_o | output | 1 | Break: whole frame sampled low |

## Verification
In the bench a tick arrives every second clock, so one bit lasts 32 clocks. The result strobe falls near the centre of the first stop bit. Counting the two synchronizer flops, the up-to-one-tick wait for edge detection and the output register, it lands about 20 clocks after the stop bit is driven. The bench timestamps every strobe and requires it to fall between 8 and 31 clocks into the stop bit. It also counts strobes over each frame and over each idle or break interval, so a missing or extra character is caught.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= 1'b1;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_os_cnt.sv
module uart_rx_os_cnt #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic mid_o,
  output logic end_o
);
  localparam int CW = $clog2(OSR);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;

  assign mid_o = tick_i && (cnt_q == CW'(OSR/2 - 1));
  assign end_o = tick_i && (cnt_q == CW'(OSR - 1));

  // counter must never advance past one bit period
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/uart_rx_par_chk.sv
module uart_rx_par_chk #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic          par_bit_i,
  input  logic          even_i,
  input  logic          stick_i,
  output logic          err_o
);
  logic ones_odd;
  assign ones_odd = ^{data_i, par_bit_i};

  always_comb begin
    if (stick_i) err_o = (par_bit_i == even_i);
    else         err_o = even_i ? ones_odd : !ones_odd;
  end
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxd_i,
  input  logic          tick_i,
  input  logic          wlen8_i,
  input  logic          par_en_i,
  input  logic          even_sel_i,
  input  logic          stick_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          par_err_o,
  output logic          frm_err_o,
  output logic          brk_o
);
  localparam int BW = $clog2(DW + 1);

  rx_state_e     state_q;
  logic          rx_s;
  logic          cnt_clr, mid_hit, end_hit;
  logic [DW-1:0] sh_q, data_al, data_q;
  logic [BW-1:0] bcnt_q;
  logic          par_q, any1_q, last_bit, perr_c;
  logic          valid_q, perr_q, ferr_q, brk_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rx_s)
  );

  uart_rx_os_cnt #(.OSR(OSR)) u_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .clr_i(cnt_clr),
    .mid_o (mid_hit), .end_o(end_hit)
  );

  // 7-bit words land in the upper bits of the shifter
  assign data_al  = wlen8_i ? sh_q : {1'b0, sh_q[DW-1:1]};
  assign last_bit = (bcnt_q == (wlen8_i ? BW'(DW-1) : BW'(DW-2)));

  uart_rx_par_chk #(.DW(DW)) u_par (
    .data_i(data_al), .par_bit_i(par_q), .even_i(even_sel_i),
    .stick_i(stick_i), .err_o(perr_c)
  );

  always_comb begin
    unique case (state_q)
      ST_IDLE, ST_BRK:          cnt_clr = 1'b1;
      ST_START:                 cnt_clr = mid_hit;
      ST_DATA, ST_PAR, ST_STOP: cnt_clr = end_hit;
      default:                  cnt_clr = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      bcnt_q  <= '0;
      par_q   <= 1'b0;
      any1_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE:
          if (tick_i && !rx_s) state_q <= ST_START;
        ST_START:
          if (mid_hit) begin
            sh_q    <= '0;
            bcnt_q  <= '0;
            par_q   <= 1'b0;
            any1_q  <= 1'b0;
            state_q <= rx_s ? ST_IDLE : ST_DATA;
          end
        ST_DATA:
          if (end_hit) begin
            sh_q   <= {rx_s, sh_q[DW-1:1]};
            any1_q <= any1_q | rx_s;
            bcnt_q <= bcnt_q + 1'b1;
            if (last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP;
          end
        ST_PAR:
          if (end_hit) begin
            par_q   <= rx_s;
            any1_q  <= any1_q | rx_s;
            state_q <= ST_STOP;
          end
        ST_STOP:
          if (end_hit) begin
            data_q  <= data_al;
            valid_q <= 1'b1;
            perr_q  <= par_en_i && perr_c;
            ferr_q  <= !rx_s;
            brk_q   <= !rx_s && !any1_q;
            state_q <= (!rx_s && !any1_q) ? ST_BRK : ST_IDLE;
          end
        ST_BRK:
          if (rx_s) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign par_err_o = perr_q;
  assign frm_err_o = ferr_q;
  assign brk_o     = brk_q;

  assert_one_clk_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_flags_need_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o || frm_err_o || brk_o) |-> valid_o);
  assert_msb_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !wlen8_i) |-> (data_o[DW-1] == 1'b0));
  assert_no_par_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !par_err_o);
  assert_brk_framing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (frm_err_o && data_o == '0));
  assert_brk_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRK && !rx_s) |=> !valid_o);
endmodule

// File: tb/sim_uart_rx_deframer.sv
module sim_uart_rx_deframer;
  localparam int BITCLK = 32;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd_i = 1'b1;
  logic       tick_i;
  logic       wlen8_i = 1'b1, par_en_i = 1'b0, even_sel_i = 1'b0, stick_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, par_err_o, frm_err_o, brk_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  int vcount = 0, vcyc = 0, stop_start = 0;
  logic [7:0] g_data;
  logic g_perr, g_ferr, g_brk;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  uart_rx_deframer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .tick_i(tick_i),
    .wlen8_i(wlen8_i), .par_en_i(par_en_i), .even_sel_i(even_sel_i), .stick_i(stick_i),
    .data_o(data_o), .valid_o(valid_o), .par_err_o(par_err_o),
    .frm_err_o(frm_err_o), .brk_o(brk_o)
  );

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tick_i <= 1'b0;
    else         tick_i <= ~tick_i;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i)
    if (rst_ni && valid_o) begin
      vcount <= vcount + 1;
      vcyc   <= cyc;
      g_data <= data_o;
      g_perr <= par_err_o;
      g_ferr <= frm_err_o;
      g_brk  <= brk_o;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd_i = v;
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit wl, input bit pe,
                            input bit pbit, input bit stopb);
    hold(1'b0, BITCLK);
    for (int i = 0; i < (wl ? 8 : 7); i++) hold(d[i], BITCLK);
    if (pe) hold(pbit, BITCLK);
    stop_start = cyc;
    hold(stopb, BITCLK);
    rxd_i = 1'b1;
  endtask

  function automatic bit good_par(input logic [7:0] d, input bit ev, input bit st);
    if (st) return ~ev;
    return ev ? ^d : ~^d;
  endfunction

  task automatic check_char(input string req, input logic [7:0] ed, input bit ep,
                            input bit ef, input bit eb);
    chk(vcount == 1, {req, " strobe count"}, vcount, 1);
    chk(g_data == ed, {req, " data"}, g_data, ed);
    chk(g_perr == ep, {req, " parity flag"}, g_perr, ep);
    chk(g_ferr == ef, {req, " framing flag"}, g_ferr, ef);
    chk(g_brk == eb, {req, " break flag"}, g_brk, eb);
    chk((vcyc - stop_start) >= 8 && (vcyc - stop_start) < BITCLK,
        {req, " R10 strobe timing"}, vcyc - stop_start, 20);
  endtask

  task automatic one(input string req, input logic [7:0] d, input bit pbit,
                     input bit stopb, input bit ep, input bit ef, input bit eb);
    logic [7:0] m;
    m = wlen8_i ? d : {1'b0, d[6:0]};
    vcount = 0;
    send_frame(d, wlen8_i, par_en_i, pbit, stopb);
    hold(1'b1, BITCLK);
    check_char(req, m, ep, ef, eb);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R11 reset state
    chk(valid_o == 0 && par_err_o == 0 && frm_err_o == 0 && brk_o == 0,
        "R11 flags in reset", {valid_o, par_err_o, frm_err_o, brk_o}, 0);
    chk(data_o == 8'h00, "R11 data in reset", data_o, 0);
    rst_ni = 1'b1;
    hold(1'b1, 4 * BITCLK);
    chk(vcount == 0, "R11 no strobe while idle", vcount, 0);

    // R1 R2 R3 R4 R5: sweep of line settings and data patterns
    for (int c = 0; c < 16; c++) begin
      wlen8_i = c[0]; par_en_i = c[1]; even_sel_i = c[2]; stick_i = c[3];
      for (int k = 0; k < 12; k++) begin
        logic [7:0] d, m;
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 73 + 5);
        m = wlen8_i ? d : {1'b0, d[6:0]};
        one(stick_i ? "R5 sweep" : par_en_i ? "R4 sweep" : "R1 R2 R3 sweep",
            d, good_par(m, even_sel_i, stick_i), 1'b1, 1'b0, 1'b0, 1'b0);
      end
    end

    // R4 R5: wrong parity bit is reported
    par_en_i = 1'b1;
    for (int c = 0; c < 8; c++) begin
      wlen8_i = c[0]; even_sel_i = c[1]; stick_i = c[2];
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d, m;
        d = 8'(k * 91 + 17);
        m = wlen8_i ? d : {1'b0, d[6:0]};
        one(stick_i ? "R5 bad parity" : "R4 bad parity",
            d, ~good_par(m, even_sel_i, stick_i), 1'b1, 1'b1, 1'b0, 1'b0);
      end
    end

    // R6 framing error on first stop bit, second stop high
    wlen8_i = 1'b1; par_en_i = 1'b0; stick_i = 1'b0; even_sel_i = 1'b0;
    one("R6 first stop low", 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R8 break with parity bit high is only a framing error
    par_en_i = 1'b1;
    one("R8 zero data parity high", 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);

    // R8 break: whole frame low, line held low afterwards
    vcount = 0;
    send_frame(8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    hold(1'b0, 4 * BITCLK);
    check_char("R8 break", 8'h00, 1'b1, 1'b1, 1'b1);
    hold(1'b1, BITCLK);
    chk(vcount == 1, "R8 no char while line low", vcount, 1);
    even_sel_i = 1'b1;
    one("R8 recovery after break", 8'hC3, good_par(8'hC3, 1'b1, 1'b0), 1'b1, 1'b0, 1'b0, 1'b0);

    // R9 short glitch rejected
    par_en_i = 1'b0;
    vcount = 0;
    hold(1'b0, 6);
    hold(1'b1, 4 * BITCLK);
    chk(vcount == 0, "R9 glitch ignored", vcount, 0);
    one("R9 char after glitch", 8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R7 back-to-back characters with one stop bit
    vcount = 0;
    send_frame(8'h3E, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(vcount == 1 && g_data == 8'h3E, "R7 first of pair", g_data, 8'h3E);
    send_frame(8'hB1, 1'b1, 1'b0, 1'b0, 1'b1);
    hold(1'b1, BITCLK);
    chk(vcount == 2, "R7 pair strobes", vcount, 2);
    chk(g_data == 8'hB1 && !g_ferr, "R7 second of pair", g_data, 8'hB1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule